// File: doc/BRIEF.md
# Bus Byte-Lane Parity Unit

This block adds per-byte parity to a 16-bit external data bus. On a write it produces one parity bit for each 8-bit lane, in the same cycle as the write data, so the bus controller can drive both together. On a read it recomputes each lane's parity from the received data, compares it with the parity lines that arrived with the data, and latches an error interrupt request if any lane disagrees.

Parity applies only to accesses whose region tag falls inside the set chosen by a two-bit enable field. A polarity bit selects odd or even parity for both lanes. A test bit forces both generated parity bits high, so software can write known bad parity and exercise the system's error detection. The error request is a sticky flag that software clears with a one-cycle clear strobe.

Top module: `bpar_unit`

## Requirements
- R1: The enable field `cfg_en` selects the checked regions: 2'b00 none, 2'b01 the DRAM region only, 2'b10 or 2'b11 both the DRAM region and the second external region. The region tag `acc_region` is 2'b01 for the DRAM region and 2'b10 for the second external region; 2'b00 and 2'b11 are never checked.
- R2: During a valid write to an enabled region, with `cfg_odd`=0 (even), `par_out[1]` is the XOR of `wr_data[15:8]` and `par_out[0]` is the XOR of `wr_data[7:0]`. `par_oe` is 1 in that same cycle, with no register delay.
- R3: With `cfg_force`=1, a valid write to an enabled region drives `par_out`=2'b11 whatever the data.
- R4: For a write outside the enabled set, or any cycle with no valid write, `par_out`=2'b00 and `par_oe`=0. A read outside the enabled set never sets `err_irq`.
- R5: A valid read from an enabled region is checked on the clock edge that samples it. If the parity of either lane is wrong, `err_irq` is 1 from the following cycle.
- R6: `err_irq` stays set until a cycle with `err_clr`=1 clears it. If a new parity error arrives in the same cycle as the clear, the flag stays set.
- R7: After synchronous reset `err_irq` is 0.
- R8: `cfg_force` has no effect on read checking.
- R9: With `cfg_odd`=1, the parity is odd for both generation and checking: each lane's data bits and its parity bit hold an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 2 | Region enable field |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_force | input | 1 | Force both write parity bits high |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_region | input | 2 | Region tag of the access |
| wr_data | input | 16 | Write data leaving the chip |
| rd_data | input | 16 | Read data arriving on the bus |
| rd_par | input | 2 | Received parity, bit 1 upper lane, bit 0 lower lane |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| par_out | output | 2 | Generated parity, bit 1 upper lane, bit 0 lower lane |
| par_oe | output | 1 | Parity output enable |
| err_irq | output | 1 | Sticky parity error interrupt request |

## Verification
The bench sweeps every enable code against every region tag. A wrong region decode shows up as parity driven or checked on an access that should be ignored, such as the second external region when the enable field is 2'b01. It injects errors on the upper lane only, the lower lane only and both lanes, so a check that OR-reduces the wrong lane is caught. It raises a clear in the same cycle as a new error, where a design that gives the clear priority would drop the interrupt. It also reads bad parity with the force bit set, where a design that leaked the force into the check would miss or invent errors, and it flips the polarity to confirm that generation and checking invert together.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'b00,
        RGN_DRAM = 2'b01,
        RGN_EXT2 = 2'b10,
        RGN_RSVD = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        EN_OFF      = 2'b00,
        EN_DRAM     = 2'b01,
        EN_BOTH     = 2'b10,
        EN_BOTH_ALT = 2'b11
    } enable_e;

    typedef struct packed {
        logic    valid;
        logic    write;
        region_e region;
    } access_t;

    typedef struct packed {
        logic odd;
        logic force_hi;
    } par_cfg_t;

endpackage

// File: rtl/bpar_region_qual.sv
module bpar_region_qual
    import bpar_pkg::*;
(
    input  enable_e en,
    input  access_t acc,
    output logic    wr_hit,
    output logic    rd_hit
);
    logic in_set;

    always_comb begin
        unique case (acc.region)
            RGN_DRAM: in_set = (en != EN_OFF);
            RGN_EXT2: in_set = (en == EN_BOTH) || (en == EN_BOTH_ALT);
            default:  in_set = 1'b0;
        endcase
        wr_hit = acc.valid &&  acc.write && in_set;
        rd_hit = acc.valid && !acc.write && in_set;
    end
endmodule

// File: rtl/bpar_lane.sv
module bpar_lane
    import bpar_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  par_cfg_t          cfg,
    input  logic [LANE_W-1:0] wr_byte,
    input  logic [LANE_W-1:0] rd_byte,
    input  logic              rd_bit,
    output logic              gen_bit,
    output logic              bad
);
    logic wr_even;
    logic rd_even;

    always_comb begin
        wr_even = ^wr_byte;
        rd_even = ^rd_byte;
        gen_bit = cfg.force_hi ? 1'b1 : (wr_even ^ cfg.odd);
        // checking ignores the force bit
        bad     = rd_bit != (rd_even ^ cfg.odd);
    end
endmodule

// File: rtl/bpar_err_flag.sv
module bpar_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
    import bpar_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_en,
    input  logic              cfg_odd,
    input  logic              cfg_force,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_region,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par,
    input  logic              err_clr,
    output logic [LANES-1:0]  par_out,
    output logic              par_oe,
    output logic              err_irq
);
    access_t          acc;
    par_cfg_t         cfg;
    logic             wr_hit;
    logic             rd_hit;
    logic [LANES-1:0] gen;
    logic [LANES-1:0] bad;

    always_comb begin
        acc.valid    = acc_valid;
        acc.write    = acc_write;
        acc.region   = region_e'(acc_region);
        cfg.odd      = cfg_odd;
        cfg.force_hi = cfg_force;
    end

    bpar_region_qual u_qual (
        .en     (enable_e'(cfg_en)),
        .acc    (acc),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bpar_lane #(.LANE_W(LANE_W)) u_lane (
            .cfg     (cfg),
            .wr_byte (wr_data[g*LANE_W +: LANE_W]),
            .rd_byte (rd_data[g*LANE_W +: LANE_W]),
            .rd_bit  (rd_par[g]),
            .gen_bit (gen[g]),
            .bad     (bad[g])
        );
    end

    always_comb begin
        par_oe  = wr_hit;
        par_out = wr_hit ? gen : '0;
    end

    bpar_err_flag u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (rd_hit && (|bad)),
        .clr  (err_clr),
        .flag (err_irq)
    );
endmodule

// File: rtl/bpar_unit_chk.sv
module bpar_unit_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_force,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             err_clr,
    input logic [LANES-1:0] par_out,
    input logic             par_oe,
    input logic             err_irq
);
    // R2
    oe_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> (acc_valid && acc_write));

    // R3
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
        (par_oe && cfg_force) |-> (par_out == '1));

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !par_oe |-> (par_out == '0));

    // R5
    err_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_irq) |-> $past(acc_valid && !acc_write));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_irq && !err_clr) |=> err_irq);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !(acc_valid && !acc_write)) |=> !err_irq);
endmodule

bind bpar_unit bpar_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_force (cfg_force),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .err_clr   (err_clr),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .err_irq   (err_irq)
);

// File: tb/tb_bpar_unit.sv
module tb_bpar_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_en;
    logic        cfg_odd, cfg_force;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_region;
    logic [15:0] wr_data, rd_data;
    logic [1:0]  rd_par;
    logic        err_clr;
    logic [1:0]  par_out;
    logic        par_oe, err_irq;

    int vectors = 0;
    int errors  = 0;
    bit m_err   = 1'b0;

    always #5 clk = ~clk;

    bpar_unit dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_odd(cfg_odd),
        .cfg_force(cfg_force), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_region(acc_region), .wr_data(wr_data), .rd_data(rd_data),
        .rd_par(rd_par), .err_clr(err_clr), .par_out(par_out),
        .par_oe(par_oe), .err_irq(err_irq)
    );

    function automatic bit ones_odd(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (b[i]) n++;
        return (n % 2) == 1;
    endfunction

    // parity bit for the chosen polarity (R2, R9)
    function automatic bit want_bit(input logic [7:0] b, input bit odd);
        bit odd_ones = ones_odd(b);
        return odd ? !odd_ones : odd_ones;
    endfunction

    // region membership (R1)
    function automatic bit enabled(input logic [1:0] en, input logic [1:0] rg);
        if (rg == 2'b01) return en != 2'b00;
        if (rg == 2'b10) return en[1];
        return 1'b0;
    endfunction

    // one cycle: drive after the falling edge, compare, then apply the model at the rising edge
    task automatic step(input string tag);
        logic [1:0] e_par;
        bit         e_oe;
        bit         hit;
        bit         set;
        hit = acc_valid && enabled(cfg_en, acc_region);
        e_oe = hit && acc_write && !rst;
        if (!e_oe) e_par = 2'b00;
        else if (cfg_force) e_par = 2'b11;
        else e_par = {want_bit(wr_data[15:8], cfg_odd), want_bit(wr_data[7:0], cfg_odd)};
        #1;
        vectors++;
        if (par_out !== e_par || par_oe !== e_oe || err_irq !== m_err) begin
            errors++;
            $display("FAIL %s: par_out=%b par_oe=%b err_irq=%b expected %b %b %b",
                     tag, par_out, par_oe, err_irq, e_par, e_oe, m_err);
        end
        @(posedge clk);
        set = hit && !acc_write &&
              ((rd_par[1] != want_bit(rd_data[15:8], cfg_odd)) ||
               (rd_par[0] != want_bit(rd_data[7:0], cfg_odd)));
        if (rst) m_err = 1'b0;
        else if (set) m_err = 1'b1;
        else if (err_clr) m_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; err_clr = 0;
    endtask

    task automatic do_write(input logic [1:0] rg, input logic [15:0] d, input string tag);
        acc_valid = 1; acc_write = 1; acc_region = rg; wr_data = d; err_clr = 0;
        step(tag);
    endtask

    // flip selects which lanes carry wrong parity: bit 1 upper, bit 0 lower
    task automatic do_read(input logic [1:0] rg, input logic [15:0] d,
                           input logic [1:0] flip, input string tag);
        acc_valid = 1; acc_write = 0; acc_region = rg; rd_data = d; err_clr = 0;
        rd_par = {want_bit(d[15:8], cfg_odd), want_bit(d[7:0], cfg_odd)} ^ flip;
        step(tag);
    endtask

    task automatic do_clear(input string tag);
        idle(); err_clr = 1; step(tag); err_clr = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1; cfg_en = 2'b11; cfg_odd = 0; cfg_force = 0;
        acc_valid = 0; acc_write = 0; acc_region = 2'b01;
        wr_data = '0; rd_data = '0; rd_par = 2'b11; err_clr = 0;
        @(negedge clk);
        step("R7 reset");
        step("R7 reset");
        rst = 0;
        step("R7 after reset");

        // R1 R2 R4: every enable code against every region tag, both polarities
        for (int od = 0; od < 2; od++) begin
            cfg_odd = od[0];
            for (int en = 0; en < 4; en++) begin
                cfg_en = en[1:0];
                for (int rg = 0; rg < 4; rg++) begin
                    do_write(rg[1:0], 16'($urandom), "R1 R2 R9 write sweep");
                    do_read(rg[1:0], 16'($urandom), 2'b11, "R1 R4 read sweep");
                    do_clear("R6 clear in sweep");
                end
            end
        end

        // R2: known data patterns, even then odd (R9)
        cfg_en = 2'b01;
        for (int od = 0; od < 2; od++) begin
            cfg_odd = od[0];
            do_write(2'b01, 16'h0000, "R2 R9 zero data");
            do_write(2'b01, 16'hFFFF, "R2 R9 all ones");
            do_write(2'b01, 16'h0180, "R2 R9 mixed lanes");
            do_write(2'b01, 16'h7F01, "R2 R9 odd upper");
            idle(); step("R4 idle cycle");
        end
        cfg_odd = 0;

        // R3: force high on enabled writes, not on disabled ones
        cfg_force = 1;
        do_write(2'b01, 16'h0000, "R3 force");
        do_write(2'b01, 16'h0303, "R3 force");
        do_write(2'b10, 16'h1234, "R3 R4 force outside set");

        // R8: force does not influence checks
        do_read(2'b01, 16'h00FF, 2'b00, "R8 good read under force");
        do_read(2'b01, 16'h0F0F, 2'b01, "R8 bad read under force");
        step("R8 error visible");
        do_clear("R6 clear");
        cfg_force = 0;

        // R5: each lane alone, then both
        for (int f = 1; f < 4; f++) begin
            do_read(2'b01, 16'($urandom), f[1:0], "R5 lane mismatch");
            step("R5 flag set");
            step("R6 flag held");
            do_clear("R6 clear");
            step("R6 after clear");
        end

        // R6: clear together with a new error keeps the flag
        do_read(2'b01, 16'hA55A, 2'b10, "R5 set");
        acc_valid = 1; acc_write = 0; acc_region = 2'b01; rd_data = 16'h1111;
        rd_par = 2'b01; err_clr = 1;
        step("R6 clear with new error");
        err_clr = 0;
        idle(); step("R6 error kept");
        do_clear("R6 clear");

        // R1: second external region checked only with enable 1x
        cfg_en = 2'b01;
        do_read(2'b10, 16'h0001, 2'b11, "R1 ext2 not checked");
        step("R1 no flag");
        cfg_en = 2'b10;
        do_read(2'b10, 16'h0001, 2'b01, "R1 ext2 checked");
        step("R1 flag from ext2");
        do_clear("R6 clear");

        // R9: odd-polarity checking
        cfg_odd = 1;
        do_read(2'b01, 16'h0000, 2'b00, "R9 odd good read");
        acc_valid = 1; acc_write = 0; rd_data = 16'h0000; rd_par = 2'b00; err_clr = 0;
        step("R9 even parity under odd");
        idle(); step("R9 flag");

        // R7: reset clears the flag
        rst = 1; step("R7 reset with flag");
        rst = 0; step("R7 flag cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule